// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the arithmetic and logic stage of a small 32-bit load-store RISC core. Each cycle the decode stage may present an operation code together with two register source values, a 16-bit immediate field and a 5-bit shift amount. The unit works out the destination value and registers it, with a valid flag, on the next rising clock edge.

The operation set contains the following:
- Register-register add and subtract.
- A sign-extended add-immediate.
- Logical shifts in both directions.
- The four bitwise functions AND, OR, XOR and NOR.
- Zero-extended immediate forms of AND, OR and XOR.
- A load-upper-immediate that places the constant in the high half of the word.

There is no bitwise NOT and no NOR-immediate. Software gets an inverse by a NOR with the zero register. A register copy is an add with the zero register. Codes outside the set produce a zero result and a one-cycle illegal-operation flag. Add and subtract wrap modulo 2^32 and never trap.

Top module: `rie_exec_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `res_valid` is high after that edge and `result` carries the value for the sampled operands. When `in_valid` is low at an edge, `res_valid` is low after it and `result` keeps its previous value.
- R2: A high `rst` at a rising edge clears `result`, `res_valid` and `illegal_op` to zero (synchronous, active-high).
- R3: Code 0 (add) gives `src_a + src_b` and code 1 (subtract) gives `src_a - src_b`. Both wrap modulo 2^32.
- R4: Code 2 (add-immediate) gives `src_a` plus `imm` sign-extended to 32 bits, so 0x8000 stands for -32768 and 0x7FFF for 32767.
- R5: Codes 9, 10 and 11 (AND, OR and XOR with immediate) combine `src_a` with `imm` zero-extended, so the high 16 bits of the constant are 0.
- R6: Code 3 shifts `src_b` left and code 4 shifts `src_b` right by `shamt` (0 to 31). Vacated bits are filled with zeros, and `src_a` has no effect on the result.
- R7: Codes 5, 6, 7 and 8 give `src_a` AND, OR, NOR and XOR `src_b` respectively. A NOR with `src_b` equal to zero yields the bitwise inverse of `src_a`.
- R8: Code 12 (load-upper) gives `imm` in bits 31..16 and zeros in bits 15..0, whatever the sources hold.
- R9: Codes 13, 14 and 15 are illegal. They give `result` 0 with `res_valid` and `illegal_op` both high for that one cycle. `illegal_op` is low in every other cycle.
- R10: An add (code 0) whose `src_b` is zero copies `src_a` unchanged into `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| src_a | input | 32 | First register source value |
| src_b | input | 32 | Second register source value |
| imm | input | 16 | Immediate constant field |
| shamt | input | 5 | Shift amount |
| res_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Registered destination value |
| illegal_op | output | 1 | The registered operation code was unsupported |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid`. There is a single register between the operand inputs and `result`, `res_valid` and `illegal_op`. The driver changes inputs only at falling edges and pushes the expected item at that moment. The monitor samples 1 ns after each rising edge, so an item pushed before an edge must be popped right after it, and the queue never holds more than one entry. Idle cycles carry random inputs, and on those cycles the monitor checks that `result` held and that no flag rose.

// File: rtl/rie_pkg.sv
`timescale 1ns/1ps
package rie_pkg;

  localparam int OP_W = 4;

  // Operation codes; values above OP_LUI are unsupported
  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDI = 4'd2,
    OP_SLL  = 4'd3,
    OP_SRL  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_NOR  = 4'd7,
    OP_XOR  = 4'd8,
    OP_ANDI = 4'd9,
    OP_ORI  = 4'd10,
    OP_XORI = 4'd11,
    OP_LUI  = 4'd12
  } rie_op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2,
    LF_NOR = 2'd3
  } rie_logic_fn_e;

endpackage

// File: rtl/rie_imm_ext.sv
`timescale 1ns/1ps
module rie_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] imm_sext,
  output logic [DATA_W-1:0] imm_zext,
  output logic [DATA_W-1:0] imm_upper
);

  localparam int PAD_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] f_sext(input logic [IMM_W-1:0] v);
    return {{PAD_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_zext(input logic [IMM_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_upper(input logic [IMM_W-1:0] v);
    return {v, {PAD_W{1'b0}}};
  endfunction

  assign imm_sext  = f_sext(imm);
  assign imm_zext  = f_zext(imm);
  assign imm_upper = f_upper(imm);

endmodule

// File: rtl/rie_barrel_shift.sv
`timescale 1ns/1ps
module rie_barrel_shift #(
  parameter int DATA_W     = 32,
  parameter int SH_W       = $clog2(DATA_W),
  parameter bit SHIFT_LEFT = 1'b1
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] dout
);

  // One stage per amount bit, stage k moves by 2**k positions
  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    if (SHIFT_LEFT) begin : g_left
      assign stage[k+1] = amt[k] ? {stage[k][DATA_W-1-DIST:0], {DIST{1'b0}}}
                                 : stage[k];
    end else begin : g_right
      assign stage[k+1] = amt[k] ? {{DIST{1'b0}}, stage[k][DATA_W-1:DIST]}
                                 : stage[k];
    end
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/rie_logic_unit.sv
`timescale 1ns/1ps
module rie_logic_unit
  import rie_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  rie_logic_fn_e     fn,
  output logic [DATA_W-1:0] dout
);

  function automatic logic [DATA_W-1:0] f_apply(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b,
                                                input rie_logic_fn_e     f);
    case (f)
      LF_AND:  return a & b;
      LF_OR:   return a | b;
      LF_XOR:  return a ^ b;
      default: return ~(a | b);
    endcase
  endfunction

  assign dout = f_apply(opa, opb, fn);

endmodule

// File: rtl/rie_exec_unit.sv
`timescale 1ns/1ps
module rie_exec_unit
  import rie_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shamt,
  output logic              res_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal_op
);

  // Named internal events, visible to the bound checker
  logic [DATA_W-1:0] imm_sext, imm_zext, imm_upper;
  logic [DATA_W-1:0] shl_out, shr_out;
  logic [DATA_W-1:0] arith_b, sum_out;
  logic              is_sub;
  logic [DATA_W-1:0] logic_b, logic_out;
  rie_logic_fn_e     logic_fn;
  logic [DATA_W-1:0] nxt_result;
  logic              dec_illegal;

  // Modulo 2^DATA_W add or subtract through one carry chain
  function automatic logic [DATA_W-1:0] f_addsub(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic              sub);
    logic [DATA_W-1:0] bb;
    bb = sub ? ~b : b;
    return a + bb + {{(DATA_W-1){1'b0}}, sub};
  endfunction

  rie_imm_ext #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_imm (
    .imm       (imm),
    .imm_sext  (imm_sext),
    .imm_zext  (imm_zext),
    .imm_upper (imm_upper)
  );

  rie_barrel_shift #(
    .DATA_W     (DATA_W),
    .SH_W       (SH_W),
    .SHIFT_LEFT (1'b1)
  ) u_shl (
    .din  (src_b),
    .amt  (shamt),
    .dout (shl_out)
  );

  rie_barrel_shift #(
    .DATA_W     (DATA_W),
    .SH_W       (SH_W),
    .SHIFT_LEFT (1'b0)
  ) u_shr (
    .din  (src_b),
    .amt  (shamt),
    .dout (shr_out)
  );

  rie_logic_unit #(
    .DATA_W (DATA_W)
  ) u_logic (
    .opa  (src_a),
    .opb  (logic_b),
    .fn   (logic_fn),
    .dout (logic_out)
  );

  // Operand steering for the adder and the logic unit
  always_comb begin
    arith_b  = src_b;
    is_sub   = 1'b0;
    logic_b  = src_b;
    logic_fn = LF_AND;
    case (op_code)
      OP_SUB:  is_sub = 1'b1;
      OP_ADDI: arith_b = imm_sext;
      OP_OR:   logic_fn = LF_OR;
      OP_NOR:  logic_fn = LF_NOR;
      OP_XOR:  logic_fn = LF_XOR;
      OP_ANDI: logic_b = imm_zext;
      OP_ORI: begin
        logic_b  = imm_zext;
        logic_fn = LF_OR;
      end
      OP_XORI: begin
        logic_b  = imm_zext;
        logic_fn = LF_XOR;
      end
      default: ;
    endcase
  end

  assign sum_out = f_addsub(src_a, arith_b, is_sub);

  // Result selection and illegal-code detection
  always_comb begin
    nxt_result  = '0;
    dec_illegal = 1'b0;
    case (op_code)
      OP_ADD, OP_SUB, OP_ADDI:                 nxt_result = sum_out;
      OP_SLL:                                  nxt_result = shl_out;
      OP_SRL:                                  nxt_result = shr_out;
      OP_AND, OP_OR, OP_NOR, OP_XOR,
      OP_ANDI, OP_ORI, OP_XORI:                nxt_result = logic_out;
      OP_LUI:                                  nxt_result = imm_upper;
      default:                                 dec_illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      illegal_op <= 1'b0;
      result     <= '0;
    end else begin
      res_valid  <= in_valid;
      illegal_op <= in_valid & dec_illegal;
      if (in_valid) begin
        result <= nxt_result;
      end
    end
  end

endmodule

// File: rtl/rie_exec_checker.sv
`timescale 1ns/1ps
module rie_exec_checker
  import rie_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [IMM_W-1:0]  imm,
  input logic [SH_W-1:0]   shamt,
  input logic              res_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal_op,
  input logic              dec_illegal
);

  localparam int PAD_W = DATA_W - IMM_W;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid); // R1

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R1

  AST_SUB_SELF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_SUB && src_a == src_b) |=> (result == '0)); // R3

  AST_ADDI_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_ADDI && src_a == '0)
      |=> (result[DATA_W-1:IMM_W] == {PAD_W{$past(imm[IMM_W-1])}})); // R4

  AST_ANDI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_ANDI) |=> (result[DATA_W-1:IMM_W] == '0)); // R5

  AST_SRL_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_SRL && shamt == '0) |=> (result == $past(src_b))); // R6

  AST_NOR_INVERT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_NOR && src_b == '0) |=> (result == ~$past(src_a))); // R7

  AST_LUI_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_LUI) |=> (result[IMM_W-1:0] == '0)); // R8

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_illegal) |=> (illegal_op && res_valid && result == '0)); // R9

  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !illegal_op); // R9

  AST_MOVE_COPY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_ADD && src_b == '0) |=> (result == $past(src_a))); // R10

endmodule

bind rie_exec_unit rie_exec_checker #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .SH_W   (SH_W)
) u_chk (.*);

// File: tb/rie_exec_unit_tb.sv
`timescale 1ns/1ps
module rie_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic        res_valid;
  logic [31:0] result;
  logic        illegal_op;

  int checks   = 0;
  int failures = 0;
  bit mon_en   = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  rie_exec_unit u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .src_a      (src_a),
    .src_b      (src_b),
    .imm        (imm),
    .shamt      (shamt),
    .res_valid  (res_valid),
    .result     (result),
    .illegal_op (illegal_op)
  );

  // Reference model written from the requirements
  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic [4:0] sh, output logic ill);
    ill = 1'b0;
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a + 32'($signed(im));
      4'd3:  return b << sh;
      4'd4:  return b >> sh;
      4'd5:  return a & b;
      4'd6:  return a | b;
      4'd7:  return ~(a | b);
      4'd8:  return a ^ b;
      4'd9:  return a & {16'h0000, im};
      4'd10: return a | {16'h0000, im};
      4'd11: return a ^ {16'h0000, im};
      4'd12: return {im, 16'h0000};
      default: begin
        ill = 1'b1;
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:         return "R3";
      4'd2:               return "R4";
      4'd3, 4'd4:         return "R6";
      4'd9, 4'd10, 4'd11: return "R5";
      4'd12:              return "R8";
      4'd13, 4'd14, 4'd15: return "R9";
      default:            return "R7";
    endcase
  endfunction

  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input logic [4:0] sh,
                      input logic [31:0] exp_res, input logic exp_ill, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    op_code  = op;
    src_a    = a;
    src_b    = b;
    imm      = im;
    shamt    = sh;
    e.res = exp_res;
    e.ill = exp_ill;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_rnd();
    logic [3:0]  op;
    logic [31:0] a, b, r;
    logic [15:0] im;
    logic [4:0]  sh;
    logic        il;
    op = 4'($urandom_range(0, 15));
    a  = $urandom;
    b  = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom;
    im = 16'($urandom);
    sh = 5'($urandom);
    r  = model(op, a, b, im, sh, il);
    send(op, a, b, im, sh, r, il, tag_of(op));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_code  = 4'($urandom);
      src_a    = $urandom;
      src_b    = $urandom;
      imm      = 16'($urandom);
      shamt    = 5'($urandom);
    end
  endtask

  task automatic check_reset_state(input string when_txt);
    checks++;
    if (result !== 32'h0 || res_valid !== 1'b0 || illegal_op !== 1'b0) begin
      failures++;
      $display("FAIL R2 %s: result=%h valid=%b illegal=%b expected result=0 valid=0 illegal=0",
               when_txt, result, res_valid, illegal_op);
    end
  endtask

  // Monitor: pops one expected item per valid result
  initial begin
    exp_t        e;
    logic [31:0] last_res;
    last_res = '0;
    forever begin
      @(posedge clk);
      #1;
      if (mon_en) begin
        if (res_valid === 1'b1) begin
          checks++;
          if (q.size() == 0) begin
            failures++;
            $display("FAIL R1 unexpected valid: result=%h expected no valid", result);
          end else begin
            e = q.pop_front();
            if (result !== e.res || illegal_op !== e.ill) begin
              failures++;
              $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                       e.tag, result, illegal_op, e.res, e.ill);
            end
          end
        end else begin
          checks++;
          if (q.size() != 0) begin
            e = q.pop_front();
            failures++;
            $display("FAIL R1 missing valid: valid=%b expected valid=1 (item %s)", res_valid, e.tag);
          end else if (result !== last_res || illegal_op !== 1'b0) begin
            failures++;
            $display("FAIL R1/R9 idle: result=%h illegal=%b expected result=%h illegal=0",
                     result, illegal_op, last_res);
          end
        end
      end
      last_res = result;
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog: actual=still running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset_state("after power-up reset");
    @(negedge clk);
    rst    = 1'b0;
    mon_en = 1'b1;

    // R3 add and subtract, wrap and operand order
    send(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, 32'h8000_0000, 1'b0, "R3 add wrap sign");
    send(4'd0, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0, 5'd0, 32'h0000_0001, 1'b0, "R3 add wrap");
    send(4'd1, 32'h0000_0005, 32'h0000_0007, 16'h0, 5'd0, 32'hFFFF_FFFE, 1'b0, "R3 sub 5-7");
    send(4'd1, 32'h0000_0007, 32'h0000_0005, 16'h0, 5'd0, 32'h0000_0002, 1'b0, "R3 sub 7-5");
    idle(1);
    // R4 add-immediate sign extension
    send(4'd2, 32'h0000_000A, 32'hFFFF_FFFF, 16'hFFFC, 5'd0, 32'h0000_0006, 1'b0, "R4 addi -4");
    send(4'd2, 32'h0000_0000, 32'h0, 16'h7FFF, 5'd0, 32'h0000_7FFF, 1'b0, "R4 addi max");
    send(4'd2, 32'h0000_0000, 32'h0, 16'h8000, 5'd0, 32'hFFFF_8000, 1'b0, "R4 addi min");
    send(4'd2, 32'h0000_0001, 32'h0, 16'hFFFF, 5'd0, 32'h0000_0000, 1'b0, "R4 addi -1");
    // R5 logical immediates zero-extended
    send(4'd9,  32'hFFFF_FFFF, 32'h0, 16'h8F0F, 5'd0, 32'h0000_8F0F, 1'b0, "R5 andi");
    send(4'd10, 32'h1234_0000, 32'h0, 16'hFFFF, 5'd0, 32'h1234_FFFF, 1'b0, "R5 ori");
    send(4'd11, 32'hFFFF_0000, 32'h0, 16'h8001, 5'd0, 32'hFFFF_8001, 1'b0, "R5 xori");
    idle(2);
    // R6 logical shifts of src_b, src_a ignored
    send(4'd3, 32'hDEAD_BEEF, 32'hB800_0009, 16'h0, 5'd4,  32'h8000_0090, 1'b0, "R6 sll 4");
    send(4'd3, 32'h0000_0000, 32'h0000_0003, 16'h0, 5'd31, 32'h8000_0000, 1'b0, "R6 sll 31");
    send(4'd4, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 5'd31, 32'h0000_0001, 1'b0, "R6 srl 31");
    send(4'd4, 32'h1357_9BDF, 32'hF000_0000, 16'h0, 5'd4,  32'h0F00_0000, 1'b0, "R6 srl zero fill");
    send(4'd4, 32'h5555_5555, 32'hC3C3_C3C3, 16'h0, 5'd0,  32'hC3C3_C3C3, 1'b0, "R6 srl 0");
    // R7 bitwise register forms
    send(4'd5, 32'h632F_0D59, 32'h0000_3C00, 16'hFFFF, 5'd0, 32'h0000_0C00, 1'b0, "R7 and");
    send(4'd6, 32'hF0F0_0000, 32'h0000_AAAA, 16'h0, 5'd0, 32'hF0F0_AAAA, 1'b0, "R7 or");
    send(4'd8, 32'hFF00_FF00, 32'h0F0F_0F0F, 16'h0, 5'd0, 32'hF00F_F00F, 1'b0, "R7 xor");
    send(4'd7, 32'h1234_5678, 32'h0000_0000, 16'h0, 5'd0, 32'hEDCB_A987, 1'b0, "R7 nor invert");
    send(4'd7, 32'h0000_0000, 32'h0000_0000, 16'h0, 5'd0, 32'hFFFF_FFFF, 1'b0, "R7 nor zero");
    idle(1);
    // R8 load-upper
    send(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hAAAA, 5'd7, 32'hAAAA_0000, 1'b0, "R8 lui");
    // R9 illegal codes, flag for one cycle only
    send(4'd13, 32'h1111_1111, 32'h2222_2222, 16'h3333, 5'd1, 32'h0, 1'b1, "R9 code 13");
    idle(1);
    send(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd3, 32'h0, 1'b1, "R9 code 14");
    send(4'd15, 32'h8000_0001, 32'h0000_0001, 16'h0001, 5'd0, 32'h0, 1'b1, "R9 code 15");
    send(4'd12, 32'h0, 32'h0, 16'h0001, 5'd0, 32'h0001_0000, 1'b0, "R9 flag drops on legal op");
    // R10 copy through add with zero
    send(4'd0, 32'hCAFE_F00D, 32'h0000_0000, 16'h0, 5'd0, 32'hCAFE_F00D, 1'b0, "R10 move");
    idle(2);

    // R2 reset in the middle of operation
    @(negedge clk);
    in_valid = 1'b0;
    rst      = 1'b1;
    mon_en   = 1'b0;
    @(posedge clk);
    #1;
    check_reset_state("after mid-run reset");
    @(negedge clk);
    rst    = 1'b0;
    mon_en = 1'b1;

    // Random mix across all codes, with idle gaps
    for (int i = 0; i < 80; i++) begin
      send_rnd();
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);
    while (q.size() != 0) @(posedge clk);
    idle(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule